// File: doc/BRIEF.md
# Gated Window Frequency Counter

This block measures the rate of a slow, already prescaled signal. A timebase made by dividing the system clock gives one tick per microsecond, and a programmable number of ticks sets a gate window. Rising edges of the input are counted while the gate is open. Once the programmed number of ticks has elapsed, the gate stays open until the next input rising edge and then closes. The edge total, which includes that closing edge, is copied into a holding register. A new window then starts at once. Because the closing edge is counted, software subtracts one from every result.

Software uses a small word-wide register interface. It writes the window length in two parts, sets or clears a hold bit, polls a ready flag, and reads the 32-bit result as two halves. The ready flag stays high until the upper half is read. If software does not read a result, the next window overwrites it. After the lower half has been read, a result that arrives is held back until the upper half has been read. This keeps the two halves from different windows.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, the ready flag is 0 and both result halves read 0.
- R2: The window length is written in two parts. Write address 0 sets length bits 15:0 from `wdata[15:0]`, and write address 1 sets bits 23:16 from `wdata[7:0]`. A programmed value d gives a gate of d+1 ticks, each tick `CLK_PER_TICK` clocks. A new value applies from the next window start.
- R3: A result equals the number of input rising edges counted while the gate was open, plus one for the rising edge that closes it. The result is 32 bits: read address 1 returns bits 15:0 and read address 2 returns bits 31:16.
- R4: A programmed length of zero never starts a window, so no result is produced.
- R5: Bit 0 of write address 2 is a hold bit, and it is 0 after reset. While it is 1, the gate is idle and any partial count is discarded. While it is 0, windows run back to back.
- R6: Read address 0 returns the ready flag in bit 0, with the other bits 0. The flag rises when a result is latched into the holding register. It stays high until a read of address 2 clears it.
- R7: An unread result stays visible until the next window completes, and is then replaced by the newer result.
- R8: After a read of address 1, any result that completes is held back. It loads the holding register, with ready high, on the next read of address 2.
- R9: After reset, the window length is `DEFAULT_DUR` (default 0x30D3F, 200000 ticks).
- R10: Only rising edges of the input are counted. An input held at a steady level never closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous prescaled input signal |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads with side effects) |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| ready | output | 1 | Result-ready flag, same as status bit 0 |

## Verification
An input rising edge reaches the edge counter on the third clock edge after the pin changes: two synchronizer stages, then the detector's delay flop. `ready` and the result halves change on the same clock edge on which the closing rise is detected. A write or a read side effect takes effect on the clock edge that samples its strobe, and `rdata` follows `addr` within that cycle. The bench model advances on each rising edge from the same strobes. Every output is compared at three quarters of the period, after the falling edge has driven the inputs, so each comparison sees the settled state from the edge just past.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    localparam int BUS_W = 16;
    localparam int ADDR_W = 2;
    localparam int CNT_W = 2 * BUS_W;

    typedef enum logic [1:0] {
        GT_IDLE = 2'd0,
        GT_OPEN = 2'd1,
        GT_TAIL = 2'd2
    } gate_st_e;

    // write-side map
    localparam logic [ADDR_W-1:0] WA_LEN_LO = 2'd0;
    localparam logic [ADDR_W-1:0] WA_LEN_HI = 2'd1;
    localparam logic [ADDR_W-1:0] WA_CTRL   = 2'd2;
    // read-side map
    localparam logic [ADDR_W-1:0] RA_STAT   = 2'd0;
    localparam logic [ADDR_W-1:0] RA_RES_LO = 2'd1;
    localparam logic [ADDR_W-1:0] RA_RES_HI = 2'd2;

    function automatic logic [BUS_W-1:0] status_word(input logic rdy);
        return {{(BUS_W-1){1'b0}}, rdy};
    endfunction

endpackage

// File: rtl/fgc_edge_sync.sv
module fgc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/fgc_gate.sv
module fgc_gate
    import fgc_pkg::*;
#(
    parameter int DUR_W = 24,
    parameter int CLK_PER_TICK = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DUR_W-1:0] dur,
    input  logic             dur_valid,
    input  logic             rise,
    output logic             done,
    output logic [CNT_W-1:0] count,
    output logic             busy
);
    localparam int DIV_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_TICK - 1);

    gate_st_e         st;
    logic [DIV_W-1:0] div;
    logic [DUR_W-1:0] left;
    logic [CNT_W-1:0] edges;
    logic             tick;

    assign tick  = (div == DIV_LAST);
    assign done  = (st == GT_TAIL) && rise && !hold;
    assign count = edges + 1'b1;
    assign busy  = (st != GT_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= GT_IDLE;
            div   <= '0;
            left  <= '0;
            edges <= '0;
        end else begin
            case (st)
                GT_IDLE: begin
                    if (!hold && dur_valid) begin
                        st    <= GT_OPEN;
                        div   <= '0;
                        left  <= dur;
                        edges <= '0;
                    end
                end
                GT_OPEN: begin
                    if (hold) begin
                        st <= GT_IDLE;
                    end else begin
                        if (rise) edges <= edges + 1'b1;
                        if (tick) begin
                            div <= '0;
                            if (left == '0) st <= GT_TAIL;
                            else            left <= left - 1'b1;
                        end else begin
                            div <= div + 1'b1;
                        end
                    end
                end
                GT_TAIL: begin
                    if (hold) begin
                        st <= GT_IDLE;
                    end else if (rise) begin
                        if (dur_valid) begin
                            st    <= GT_OPEN;
                            div   <= '0;
                            left  <= dur;
                            edges <= '0;
                        end else begin
                            st <= GT_IDLE;
                        end
                    end
                end
                default: st <= GT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fgc_regs.sv
module fgc_regs
    import fgc_pkg::*;
#(
    parameter int DUR_W = 24,
    parameter int unsigned DEFAULT_DUR = 32'h30D3F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              done,
    input  logic [CNT_W-1:0]  count,
    output logic [DUR_W-1:0]  dur_q,
    output logic              hold_q,
    output logic              ready,
    output logic [CNT_W-1:0]  held_q
);
    localparam int HI_W = DUR_W - BUS_W;

    logic             lock_q;
    logic             pend_v;
    logic [CNT_W-1:0] pend_q;
    logic             locked;

    // a pair read is open from the low-half read until the high-half read
    assign locked = (lock_q | rd_lo) & ~rd_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            dur_q  <= DUR_W'(DEFAULT_DUR);
            hold_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                WA_LEN_LO: dur_q[BUS_W-1:0]     <= wdata;
                WA_LEN_HI: dur_q[DUR_W-1:BUS_W] <= wdata[HI_W-1:0];
                WA_CTRL:   hold_q               <= wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            pend_v <= 1'b0;
            pend_q <= '0;
            held_q <= '0;
            ready  <= 1'b0;
        end else begin
            lock_q <= locked;
            if (rd_hi) begin
                pend_v <= 1'b0;
                if (pend_v) begin
                    held_q <= pend_q;
                    ready  <= 1'b1;
                end else begin
                    ready  <= 1'b0;
                end
            end
            if (done) begin
                if (locked) begin
                    pend_q <= count;
                    pend_v <= 1'b1;
                end else begin
                    held_q <= count;
                    ready  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
    import fgc_pkg::*;
#(
    parameter int CLK_PER_TICK = 50,
    parameter int DUR_W = 24,
    parameter int unsigned DEFAULT_DUR = 32'h30D3F,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sig_in,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        ready
);
    logic             rise;
    logic             rd_lo;
    logic             rd_hi;
    logic [DUR_W-1:0] dur_q;
    logic             dur_valid;
    logic             hold_q;
    logic             win_done;
    logic [CNT_W-1:0] win_count;
    logic             gate_busy;
    logic [CNT_W-1:0] held_q;

    assign rd_lo     = rd_en && (addr == RA_RES_LO);
    assign rd_hi     = rd_en && (addr == RA_RES_HI);
    assign dur_valid = |dur_q;

    fgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(sig_in), .rise(rise)
    );

    fgc_gate #(.DUR_W(DUR_W), .CLK_PER_TICK(CLK_PER_TICK)) u_gate (
        .clk(clk), .rst(rst), .hold(hold_q), .dur(dur_q),
        .dur_valid(dur_valid), .rise(rise), .done(win_done),
        .count(win_count), .busy(gate_busy)
    );

    fgc_regs #(.DUR_W(DUR_W), .DEFAULT_DUR(DEFAULT_DUR)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .done(win_done), .count(win_count),
        .dur_q(dur_q), .hold_q(hold_q), .ready(ready), .held_q(held_q)
    );

    always_comb begin
        case (addr)
            RA_STAT:   rdata = status_word(ready);
            RA_RES_LO: rdata = held_q[BUS_W-1:0];
            RA_RES_HI: rdata = held_q[CNT_W-1:BUS_W];
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ready,
    input logic             done,
    input logic             rd_lo,
    input logic             rd_hi,
    input logic             hold,
    input logic             busy,
    input logic             dur_valid,
    input logic [CNT_W-1:0] held
);
    p_ready_set_r6: assert property (@(posedge clk) disable iff (rst)
        (done && rd_hi) |=> ready);

    p_ready_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (ready && !rd_hi) |=> ready);

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        hold |=> !busy);

    p_zero_len_r4: assert property (@(posedge clk) disable iff (rst)
        (!dur_valid && !busy) |=> !busy);

    p_held_source_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(held) |-> ($past(done) || $past(rd_hi)));

    p_pair_defer_r8: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> $stable(held));
endmodule

bind freq_gate_counter fgc_checker #(.CNT_W(32)) u_fgc_chk (
    .clk(clk), .rst(rst), .ready(ready), .done(win_done), .rd_lo(rd_lo),
    .rd_hi(rd_hi), .hold(hold_q), .busy(gate_busy), .dur_valid(dur_valid),
    .held(held_q)
);

// File: tb/test_freq_gate_counter.sv
module test_freq_gate_counter;
    localparam int CLK_PERIOD = 8;
    localparam int CPT = 2;
    localparam int DEF_DUR = 9;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sig_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        ready;

    int errors = 0;
    int checks = 0;
    int half = 3;
    int ph_cnt = 0;
    bit tog_en = 1'b1;
    bit live = 1'b0;
    int cyc = 0;

    freq_gate_counter #(.CLK_PER_TICK(CPT), .DEFAULT_DUR(DEF_DUR)) i_freq_gate_counter (
        .clk(clk), .rst(rst), .sig_in(sig_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // input stimulus: square wave of period 2*half clocks
    always @(negedge clk) begin
        if (tog_en) begin
            if (ph_cnt + 1 >= half) begin
                sig_in <= ~sig_in;
                ph_cnt <= 0;
            end else begin
                ph_cnt <= ph_cnt + 1;
            end
        end
    end

    // behavioural reference model
    bit          m_s1, m_s2, m_s3;
    int          m_st;          // 0 idle, 1 gate open, 2 waiting for closing edge
    int          m_div;
    int          m_left;
    logic [31:0] m_edges, m_res, m_pend;
    logic [23:0] m_dur;
    bit          m_hold, m_ready, m_lock, m_pv;

    always @(posedge clk) begin
        bit e, dn, rlo, rhi, lkd;
        logic [31:0] v;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_st = 0; m_div = 0; m_left = 0;
            m_edges = 0; m_res = 0; m_pend = 0; m_dur = 24'(DEF_DUR);
            m_hold = 0; m_ready = 0; m_lock = 0; m_pv = 0;
            live = 1'b1;
        end else begin
            e = m_s2 && !m_s3;
            dn = 0; v = 0;
            if (m_st == 0) begin
                if (!m_hold && m_dur != 0) begin
                    m_st = 1; m_div = 0; m_left = int'(m_dur); m_edges = 0;
                end
            end else if (m_st == 1) begin
                if (m_hold) m_st = 0;
                else begin
                    if (e) m_edges = m_edges + 1;
                    if (m_div == CPT - 1) begin
                        m_div = 0;
                        if (m_left == 0) m_st = 2; else m_left = m_left - 1;
                    end else m_div = m_div + 1;
                end
            end else begin
                if (m_hold) m_st = 0;
                else if (e) begin
                    dn = 1; v = m_edges + 1;
                    if (m_dur != 0) begin
                        m_st = 1; m_div = 0; m_left = int'(m_dur); m_edges = 0;
                    end else m_st = 0;
                end
            end
            rlo = rd_en && addr == 2'd1;
            rhi = rd_en && addr == 2'd2;
            lkd = (m_lock || rlo) && !rhi;
            m_lock = lkd;
            if (rhi) begin
                if (m_pv) begin m_res = m_pend; m_ready = 1; end
                else m_ready = 0;
                m_pv = 0;
            end
            if (dn) begin
                if (lkd) begin m_pend = v; m_pv = 1; end
                else begin m_res = v; m_ready = 1; end
            end
            if (wr_en) begin
                if (addr == 2'd0) m_dur[15:0] = wdata;
                else if (addr == 2'd1) m_dur[23:16] = wdata[7:0];
                else if (addr == 2'd2) m_hold = wdata[0];
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig_in;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {15'd0, m_ready};
            2'd1: return m_res[15:0];
            2'd2: return m_res[31:16];
            default: return 16'd0;
        endcase
    endfunction

    // per-clock comparison against the model
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (live && !rst) begin
            checks++;
            if (ready !== m_ready) begin
                errors++;
                $display("FAIL R6 ready flag: actual=%0b expected=%0b", ready, m_ready);
            end
            checks++;
            if (rdata !== exp_rd(addr)) begin
                errors++;
                $display("FAIL %s rdata at addr %0d: actual=%h expected=%h",
                         (addr == 2'd0) ? "R6" : "R3", addr, rdata, exp_rd(addr));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #(CLK_PERIOD/4);
        d = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd_pair(output logic [31:0] r);
        logic [15:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        r = {hi, lo};
    endtask

    task automatic wait_ready(input int limit, output int took);
        took = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (ready) begin took = i; break; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        logic [31:0] r;
        int took;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 ready after reset", ready == 1'b0, ready, 0);
        rd(2'd1, d); chk("R1 result low after reset", d == 16'd0, d, 0);
        rd(2'd2, d); chk("R1 result high after reset", d == 16'd0, d, 0);

        // R9: default window of DEF_DUR+1 ticks, period 6 clocks
        wait_ready(400, took);
        chk("R9 first result timing (cycles)",
            took + 5 >= (DEF_DUR + 1) * CPT && took <= (DEF_DUR + 1) * CPT + 2 * half + 10,
            took, (DEF_DUR + 1) * CPT);
        rd_pair(r);
        chk("R3 result for 20-clock window, period 6", r >= 3 && r <= 5, r, 4);
        chk("R6 ready cleared by high-half read", ready == 1'b0, ready, 0);

        // R2: 30-tick window
        wr(2'd0, 16'd29);
        wr(2'd1, 16'd0);
        wait_ready(400, took); rd_pair(r);
        wait_ready(400, took); rd_pair(r);
        chk("R2 result for 60-clock window, period 6", r >= 10 && r <= 12, r, 11);

        // R7: leave results unread across several windows
        wait_ready(400, took);
        idle(150);
        chk("R7 ready held while unread", ready == 1'b1, ready, 1);

        // R8: low half read, then a window completes before the high half
        rd(2'd1, d);
        idle(150);
        rd(2'd2, d);
        chk("R8 deferred result delivered with ready", ready == 1'b1, ready, 1);
        rd_pair(r);
        chk("R6 ready cleared after drain", ready == 1'b0, ready, 0);

        // R5: hold stops measurement, release restarts it
        wr(2'd2, 16'd1);
        rd_pair(r);
        idle(300);
        chk("R5 no result while held", ready == 1'b0, ready, 0);
        wr(2'd2, 16'd0);
        wait_ready(400, took);
        chk("R5 result resumes after release", took >= 0, took, 1);

        // R4: zero length never starts a window
        wr(2'd2, 16'd1);
        rd_pair(r);
        wr(2'd0, 16'd0);
        wr(2'd2, 16'd0);
        idle(300);
        chk("R4 zero length gives no result", ready == 1'b0, ready, 0);

        // R10: steady input never closes a window
        wr(2'd0, 16'd29);
        wait_ready(400, took);
        tog_en = 1'b0;
        idle(10);
        rd_pair(r);
        idle(300);
        chk("R10 steady input gives no result", ready == 1'b0, ready, 0);

        // R2: upper length bits, 0x10000 ticks, period 256 clocks
        half = 128;
        ph_cnt = 0;
        tog_en = 1'b1;
        wr(2'd1, 16'd1);
        wr(2'd0, 16'd0);
        wait_ready(1000, took);
        chk("R2 window ahead of long window completes", took >= 0, took, 1);
        rd_pair(r);
        wait_ready(140000, took);
        rd_pair(r);
        chk("R2 result for 0x10000+1 tick window", r >= 512 && r <= 515, r, 513);

        idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule